// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the serial half of an SPI master port. It pulls frames from a transmit queue through a valid/ready handshake, shifts each one out on MOSI with the most significant bit first, and samples MISO on the opposite clock edge. Each received frame is delivered as a one-cycle pulse with the data right-justified. The serial clock comes from two counters in series. The first is an even prescaler and the second is a rate counter, so the full SCLK period is `prescale * (1 + rate)` input clocks. The fastest setting is half the input clock and the slowest is 1/(254*256) of it.

Frame length, clock polarity, clock phase and the rate field all come from one 16-bit control word. The block latches these settings when a frame is taken from the queue. When a frame ends and another is already waiting, the next frame starts on the same clock edge, so the serial clock never pauses between frames. A loopback input sends the transmitted bit stream straight to the receiver. Chip-select generation and slave operation are not part of this block.

Top module: `spi_shift_master`

## Requirements
- R1: The SCLK half-period is `(P/2) * (1 + rate)` input clock cycles. P is the effective prescale value and rate is `ctrl_i[15:8]`.
- R2: The effective prescale value is derived from `prescale_i` as follows: 0 becomes 2, an odd value becomes the next even value, and 255 becomes 254.
- R3: A frame has `ctrl_i[3:0] + 1` bits, which gives 4 to 16 bits. A field value below 3 gives 4-bit frames. Each frame produces exactly 2N SCLK edges.
- R4: MOSI carries bit N-1 of `tx_data_i` first and bit 0 last. Bits above N-1 are never sent. `rx_data_o` holds the received bits right-justified, first bit at position N-1, with zeros above.
- R5: `ctrl_i[7]` is the polarity: SCLK rests at this level whenever no frame is active. `ctrl_i[6]` is the phase. With phase 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R6: With `loop_i` high, each received frame equals the transmitted frame, and `miso_i` has no effect.
- R7: When `tx_valid_i` is high at the final edge of a frame, the next frame starts at once. Every pair of consecutive SCLK edges, including the pair across the frame boundary, is exactly one half-period apart.
- R8: `busy_o` is high while a frame is active, or while `en_i` and `tx_valid_i` are both high. Otherwise it is low.
- R9: With `en_i` low, `tx_ready_o` stays low and no frame starts.
- R10: Every completed frame gives exactly one single-cycle `rx_valid_o` pulse.
- R11: After reset, `sclk_o`, `mosi_o`, `busy_o`, `rx_valid_o` and `tx_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; frames start only when high |
| loop_i | input | 1 | Internal loopback of MOSI to the receiver |
| ctrl_i | input | 16 | [15:8] rate, [7] polarity, [6] phase, [3:0] bits minus one |
| prescale_i | input | 8 | Prescale value, normalised to an even value from 2 to 254 |
| tx_valid_i | input | 1 | Transmit queue holds a frame |
| tx_data_i | input | 16 | Transmit frame, right-justified |
| tx_ready_o | output | 1 | Frame taken this cycle when valid is also high |
| rx_valid_o | output | 1 | One-cycle pulse with a received frame |
| rx_data_o | output | 16 | Received frame, right-justified |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Engine active or work pending |

## Verification
The bench acts as a slave that drives MISO and collects MOSI according to the phase rules, and it timestamps every SCLK edge. This lets it catch a divider that is off by one cycle, or one that wraps odd or zero prescale values wrongly; either fault shows up as a wrong edge spacing. Bursts of several frames expose a gap inserted at the frame boundary, and a phase that samples on the wrong edge, which returns shifted data. Short size fields, high bits set in the transmit word, and loopback with a conflicting MISO stream target a wrong bit count, upper bits that are not zeroed, and a receiver that still listens to the pin.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int FRAME_W  = 16;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int CNT_W    = IDX_W + 1;
  localparam int PRE_W    = 8;
  localparam int RATE_W   = 8;
  localparam int CTRL_W   = 16;
  localparam int MIN_BITS = 4;
  // control word field positions
  localparam int RATE_LSB = 8;
  localparam int CPOL_BIT = 7;
  localparam int CPHA_BIT = 6;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic [IDX_W-1:0]  size_m1;
    logic [RATE_W-1:0] rate;
    logic [PRE_W-2:0]  pre_half;
  } cfg_t;
endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
  import spi_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [PRE_W-1:0]  prescale_i,
  output cfg_t              cfg_o
);
  localparam logic [IDX_W-1:0] MIN_M1 = IDX_W'(MIN_BITS - 1);
  localparam logic [PRE_W-2:0] HALF_MIN = 1;
  localparam logic [PRE_W-2:0] HALF_MAX = '1;

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_i[CPHA_BIT-1:IDX_W];

  always_comb begin
    cfg_o.cpol    = ctrl_i[CPOL_BIT];
    cfg_o.cpha    = ctrl_i[CPHA_BIT];
    cfg_o.rate    = ctrl_i[RATE_LSB +: RATE_W];
    cfg_o.size_m1 = (ctrl_i[IDX_W-1:0] < MIN_M1) ? MIN_M1 : ctrl_i[IDX_W-1:0];
    // half of the prescale value, rounded up to even, clamped to 2..max even
    if (prescale_i == '0)
      cfg_o.pre_half = HALF_MIN;
    else if (&prescale_i)
      cfg_o.pre_half = HALF_MAX;
    else
      cfg_o.pre_half = prescale_i[PRE_W-1:1] + {{(PRE_W-2){1'b0}}, prescale_i[0]};
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PRE_W-2:0]  pre_half_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam logic [PRE_W-2:0]  PRE_ONE  = 1;
  localparam logic [RATE_W-1:0] RATE_ONE = 1;

  logic [PRE_W-2:0]  pre_q;
  logic [RATE_W-1:0] rate_q;
  logic              pre_wrap, rate_wrap;

  assign pre_wrap  = (pre_q == pre_half_i - PRE_ONE);
  assign rate_wrap = (rate_q == rate_i);
  assign tick_o    = run_i & pre_wrap & rate_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else if (!run_i) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else if (pre_wrap) begin
      pre_q  <= '0;
      rate_q <= rate_wrap ? '0 : rate_q + RATE_ONE;
    end else begin
      pre_q <= pre_q + PRE_ONE;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               loop_i,
  input  cfg_t               cfg_i,
  input  logic               tx_valid_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               miso_i,
  input  logic               tick_i,
  output logic               run_o,
  output cfg_t               cfg_o,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               sclk_o,
  output logic               mosi_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [IDX_W-1:0] IDX_ONE = 1;

  logic               act_q, sclk_q, rx_valid_q;
  cfg_t               cfg_q;
  logic [FRAME_W-1:0] tx_q, rx_q, rx_data_q, rx_next;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   edge_cnt_q;
  logic step, leading, last, sample_now, shift_now, load, bit_out, miso_eff;

  always_comb begin
    step       = act_q & tick_i;
    leading    = ~edge_cnt_q[0];
    last       = step & (edge_cnt_q == {cfg_q.size_m1, 1'b1});
    // phase 0 samples on leading edges, phase 1 on trailing edges
    sample_now = step & (leading ^ cfg_q.cpha);
    shift_now  = step & ~(leading ^ cfg_q.cpha) & (edge_cnt_q != '0);
    bit_out    = tx_q[idx_q];
    miso_eff   = loop_i ? bit_out : miso_i;
    rx_next    = sample_now ? ((rx_q << 1) | FRAME_W'(miso_eff)) : rx_q;
    tx_ready_o = en_i & (~act_q | last);
    load       = tx_ready_o & tx_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      cfg_q      <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      idx_q      <= '0;
      edge_cnt_q <= '0;
      sclk_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= last;
      if (last) rx_data_q <= rx_next;

      if (load) begin
        act_q      <= 1'b1;
        cfg_q      <= cfg_i;
        tx_q       <= tx_data_i;
        idx_q      <= cfg_i.size_m1;
        edge_cnt_q <= '0;
        rx_q       <= '0;
      end else if (last) begin
        act_q <= 1'b0;
      end else if (step) begin
        edge_cnt_q <= edge_cnt_q + CNT_ONE;
        rx_q       <= rx_next;
        if (shift_now) idx_q <= idx_q - IDX_ONE;
      end

      if (load)        sclk_q <= cfg_i.cpol;
      else if (step)   sclk_q <= ~sclk_q;
      else if (!act_q) sclk_q <= cfg_i.cpol;
    end
  end

  assign run_o      = act_q;
  assign cfg_o      = cfg_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = act_q & bit_out;
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               loop_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  input  logic [PRE_W-1:0]   prescale_i,
  input  logic               tx_valid_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               busy_o
);
  cfg_t cfg_live, cfg_run;
  logic run, tick;

  spi_cfg_decode u_dec (
    .ctrl_i     (ctrl_i),
    .prescale_i (prescale_i),
    .cfg_o      (cfg_live)
  );

  spi_clk_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .pre_half_i (cfg_run.pre_half),
    .rate_i     (cfg_run.rate),
    .tick_o     (tick)
  );

  spi_shifter u_shf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .loop_i     (loop_i),
    .cfg_i      (cfg_live),
    .tx_valid_i (tx_valid_i),
    .tx_data_i  (tx_data_i),
    .miso_i     (miso_i),
    .tick_i     (tick),
    .run_o      (run),
    .cfg_o      (cfg_run),
    .tx_ready_o (tx_ready_o),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o)
  );

  assign busy_o = run | (en_i & tx_valid_i);
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk
  import spi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              tx_ready_o,
  input logic              rx_valid_o,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic              busy_o,
  input logic              run_i,
  input logic              tick_i
);
  a_r1_sclk_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(tick_i)) |-> $stable(sclk_o));

  a_r4_mosi_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(tick_i)) |-> $stable(mosi_o));

  a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !run_i && !$past(run_i)) |-> (sclk_o == $past(ctrl_i[CPOL_BIT])));

  a_r8_busy_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> busy_o);

  a_r9_no_ready_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tx_ready_o);

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .ctrl_i     (ctrl_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .busy_o     (busy_o),
  .run_i      (run),
  .tick_i     (tick)
);

// File: tb/tb_spi_shift_master.sv
module tb_spi_shift_master;
  localparam int CLK_PERIOD = 10;
  localparam int MAXK = 4;

  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, loop_en = 1'b0;
  logic [15:0] ctrl = '0;
  logic [7:0]  pre = 8'd2;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid, sclk, mosi, busy;
  logic [15:0] rx_data;
  logic        miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_master dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .loop_i(loop_en),
    .ctrl_i(ctrl), .prescale_i(pre),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .busy_o(busy)
  );

  int total = 0, bad = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int unsigned act, input int unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model and edge monitor
  bit          mon_on = 0, m_cpol = 0, m_cpha = 0;
  logic        prev_sclk = 0, prev_mosi = 0;
  int          m_n = 4, exp_h = 1, kk = 0, s_w = 0, s_bit = 0;
  int          last_t = -1, bad_int = 0, nedges = 0, nrx = 0;
  logic [15:0] acc = '0;
  logic [15:0] resp [MAXK];
  logic [15:0] got_mosi [MAXK];
  logic [15:0] got_rx [MAXK];

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (rx_valid) begin
        if (nrx < MAXK) got_rx[nrx] = rx_data;
        nrx++;
      end
      if (sclk !== prev_sclk) begin
        if (last_t >= 0 && (cyc - last_t) != exp_h) bad_int++;
        last_t = cyc;
        nedges++;
        if (sclk != m_cpol) begin
          if (!m_cpha) acc = {acc[14:0], prev_mosi};
          else miso = (s_w < kk) ? resp[s_w][m_n-1-s_bit] : 1'b0;
        end else begin
          if (m_cpha) acc = {acc[14:0], prev_mosi};
          s_bit++;
          if (s_bit == m_n) begin
            if (s_w < MAXK) got_mosi[s_w] = acc;
            s_w++; s_bit = 0; acc = '0;
          end
          if (!m_cpha) miso = (s_w < kk) ? resp[s_w][m_n-1-s_bit] : 1'b0;
        end
      end
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  function automatic int exp_half(input int p, input int r);
    int ep;
    if (p == 0) ep = 2;
    else if (p == 255) ep = 254;
    else if (p % 2 == 1) ep = p + 1;
    else ep = p;
    return (ep / 2) * (r + 1);
  endfunction

  function automatic int frame_bits(input int nf);
    return (nf < 3) ? 4 : nf + 1;
  endfunction

  task automatic burst(input bit cpol, input bit cpha, input int nf, input int p,
                       input int r, input bit lp, input int k, input string tg);
    int n, fi, guard;
    bit a;
    logic [15:0] mask, ex;
    logic [15:0] txw [MAXK];
    n = frame_bits(nf);
    mask = 16'((32'd1 << n) - 1);
    @(negedge clk);
    mon_on = 0; en = 0; tx_valid = 0;
    ctrl = {8'(r), cpol, cpha, 2'b00, 4'(nf)};
    pre = 8'(p); loop_en = lp;
    for (int i = 0; i < MAXK; i++) begin
      txw[i] = 16'($urandom); resp[i] = 16'($urandom);
      got_mosi[i] = '0; got_rx[i] = '0;
    end
    m_cpol = cpol; m_cpha = cpha; m_n = n; exp_h = exp_half(p, r); kk = k;
    s_w = 0; s_bit = 0; acc = '0; nrx = 0; last_t = -1; bad_int = 0; nedges = 0;
    miso = cpha ? 1'b0 : resp[0][n-1];
    @(negedge clk); @(negedge clk);
    check(sclk === cpol, "R5", "idle level before burst", 32'(sclk), 32'(cpol));
    mon_on = 1; en = 1; tx_valid = 1; tx_data = txw[0]; fi = 0;
    #1;
    check(busy === 1'b1, "R8", "busy with pending frame", 32'(busy), 1);
    a = tx_valid && tx_ready;
    guard = 0;
    while (fi < k && guard < 60000) begin
      @(negedge clk); guard++;
      if (a) begin
        fi++;
        if (fi < k) tx_data = txw[fi];
        else tx_valid = 0;
      end
      #1;
      a = tx_valid && tx_ready;
    end
    while (nrx < k && guard < 60000) begin
      @(negedge clk); guard++;
    end
    repeat (2 * exp_h + 4) @(negedge clk);
    check(nrx == k, "R10", "received frame count", 32'(nrx), 32'(k));
    check(s_w == k && s_bit == 0, "R3", "slave frames", 32'(s_w), 32'(k));
    check(nedges == 2 * n * k, "R3", "edge count", 32'(nedges), 32'(2 * n * k));
    check(bad_int == 0, tg, "edge spacing errors", 32'(bad_int), 0);
    for (int i = 0; i < k; i++) begin
      ex = txw[i] & mask;
      check(got_mosi[i] == ex, "R4", "mosi word", 32'(got_mosi[i]), 32'(ex));
      ex = lp ? (txw[i] & mask) : (resp[i] & mask);
      check(got_rx[i] == ex, lp ? "R6" : "R4/R5", "rx word", 32'(got_rx[i]), 32'(ex));
    end
    check(busy === 1'b0, "R8", "busy after burst", 32'(busy), 0);
    check(sclk === cpol, "R5", "idle level after burst", 32'(sclk), 32'(cpol));
    mon_on = 0; en = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(sclk === 1'b0, "R11", "sclk after reset", 32'(sclk), 0);
    check(mosi === 1'b0, "R11", "mosi after reset", 32'(mosi), 0);
    check(busy === 1'b0, "R11", "busy after reset", 32'(busy), 0);
    check(rx_valid === 1'b0, "R11", "rx_valid after reset", 32'(rx_valid), 0);
    check(tx_ready === 1'b0, "R11", "tx_ready after reset", 32'(tx_ready), 0);

    // fastest clock, back-to-back frames
    burst(0, 0, 7, 2, 0, 0, 3, "R1/R7");
    // remaining modes, full width
    burst(0, 1, 15, 4, 1, 0, 2, "R1/R7");
    burst(1, 0, 15, 4, 1, 0, 2, "R1/R7");
    burst(1, 1, 15, 4, 1, 0, 2, "R1/R7");
    // short size fields give 4-bit frames (R3)
    burst(0, 0, 0, 2, 1, 0, 2, "R3");
    burst(1, 1, 2, 6, 0, 0, 2, "R3");
    // prescale normalisation (R2)
    burst(0, 1, 5, 0, 2, 0, 1, "R2");
    burst(1, 0, 9, 7, 0, 0, 2, "R2");
    burst(0, 0, 3, 255, 0, 0, 1, "R2");
    // large rate field (R1)
    burst(1, 1, 3, 2, 255, 0, 1, "R1");
    // loopback ignores miso (R6)
    burst(1, 1, 11, 2, 0, 1, 3, "R6");
    burst(0, 0, 4, 3, 1, 1, 2, "R6");

    // R9: disabled port takes nothing
    @(negedge clk);
    en = 0; tx_valid = 1; tx_data = 16'hA5C3;
    nrx = 0; nedges = 0; last_t = -1; m_cpol = sclk; mon_on = 1; seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (tx_ready) seen = 1;
    end
    check(seen == 0, "R9", "tx_ready while disabled", 32'(seen), 0);
    check(nedges == 0, "R9", "sclk edges while disabled", 32'(nedges), 0);
    check(nrx == 0, "R9", "frames while disabled", 32'(nrx), 0);
    check(busy === 1'b0, "R8", "busy while disabled", 32'(busy), 0);
    mon_on = 0; tx_valid = 0;

    // constrained random bursts
    for (int t = 0; t < 16; t++) begin
      burst(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 16),
            int'($urandom % 10), int'($urandom % 4), ($urandom % 4) == 0,
            1 + int'($urandom % 3), "R1/R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule